// File: doc/BRIEF.md
# Seven-Segment Space-Vector Gate Sequencer

The block turns one sampling period's worth of space-vector modulation data into leg commands for a two-level three-phase bridge. At each period boundary it takes a sector number (1 to 6) and three dwell times, each counted in clock ticks: `ta_i` and `tb_i` for the two active vectors that bound the sector, and `t0_i` for the zero vector. It then plays a mirrored seven-step pattern. The pattern opens and closes in the all-low zero state and holds the all-high zero state in the middle. Each leg output selects the upper switch (1) or the lower switch (0) of its half-bridge.

The zero time is shared between the two zero states. A quarter of it goes to each outer step, and the centre step takes the rest. Because every sector's pattern begins and ends all-low, a new sector at the boundary costs no extra switching. Inputs are read only at the boundary. Dead-time insertion and the computation of the dwell times belong to other blocks.

Top module: `svm7_gate_seq`

## Requirements
- R1: While `rst_n` is low, `leg_o` is 000 and `start_o` is 0. The first clock edge after reset is released starts a period and samples the inputs at that edge.
- R2: A period lasts L = max(ta+tb+t0, 1) clock cycles. `start_o` is 1 exactly in the first cycle of each period. The next period starts directly after the last cycle.
- R3: The seven steps last, in order, q, d1, d2, c, d2, d1 and q cycles. Here q = floor(t0/4), the pair {d1, d2} is {floor(ta/2), floor(tb/2)} ordered as in R4/R5, and c = (ta+tb+t0) − 2q − 2·floor(ta/2) − 2·floor(tb/2). The centre therefore absorbs every odd remainder tick.
- R4: The leg encoding is `leg_o[0]` = leg A, `[1]` = B, `[2]` = C, with 1 = upper switch on. The vectors are V1=POO (001), V2=PPO (011), V3=OPO (010), V4=OPP (110), V5=OOP (100), V6=POP (101). In odd sector n the steps are 000, Vn, Vn+1, 111, Vn+1, Vn, 000. Vn lasts floor(ta/2) and Vn+1 lasts floor(tb/2).
- R5: In even sector n the active vectors come in reverse order: 000, Vn+1 for floor(tb/2), Vn for floor(ta/2), 111, then the mirror image. V7 means V1.
- R6: The outer steps are 000 and the centre step is 111. When all seven steps are non-empty, each cycle-to-cycle change flips at most one leg. This holds across period boundaries too, and each leg goes high once and low once per period.
- R7: Changes to `sector_i`, `ta_i`, `tb_i` and `t0_i` during a period have no effect on that period.
- R8: A sector value of 0 or 7 gives a period of length L with `leg_o` = 000 throughout.
- R9: A step of zero length does not appear. For example, t0 < 4 makes the period open directly in its first active vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick of dwell time per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sector_i | input | 3 | Sector number 1..6, sampled at the period boundary |
| ta_i | input | TW | Dwell of the first active vector of the sector, in ticks |
| tb_i | input | TW | Dwell of the second active vector of the sector, in ticks |
| t0_i | input | TW | Total zero-vector dwell, in ticks |
| leg_o | output | 3 | Per-leg command, bit 0 = A, 1 = upper switch on |
| start_o | output | 1 | High in the first cycle of each period |

## Verification
Every output is registered. The values for tick k of a period appear in the cycle after the edge that advanced the counter to k. The inputs are taken at the edge that ends the previous period's last tick, and tick 0 of the new period, with `start_o` high, is visible in the cycle that follows. The bench drives inputs and samples outputs on the falling edge. A queue-based model is advanced once per falling edge using the inputs that were present at the preceding rising edge, so each expected value lines up with the cycle in which the design registers it. Between boundaries the bench keeps scrambling the inputs, so every period also checks that changes mid-period are ignored.

// File: rtl/svm7_pkg.sv
package svm7_pkg;

    localparam int NUM_LEGS   = 3;
    localparam int NUM_EDGES  = 6;
    localparam logic [1:0] RANK_NEVER = 2'd3;

    // Rank of a leg: 0 turns on first (longest high), 2 turns on last.
    typedef logic [NUM_LEGS-1:0][1:0] rank_set_t;

    // Index 0 = leg A, 1 = leg B, 2 = leg C.
    function automatic rank_set_t sector_ranks(input logic [2:0] sect);
        rank_set_t r;
        case (sect)
            3'd1:    begin r[0] = 2'd0; r[1] = 2'd1; r[2] = 2'd2; end
            3'd2:    begin r[0] = 2'd1; r[1] = 2'd0; r[2] = 2'd2; end
            3'd3:    begin r[0] = 2'd2; r[1] = 2'd0; r[2] = 2'd1; end
            3'd4:    begin r[0] = 2'd2; r[1] = 2'd1; r[2] = 2'd0; end
            3'd5:    begin r[0] = 2'd1; r[1] = 2'd2; r[2] = 2'd0; end
            3'd6:    begin r[0] = 2'd0; r[1] = 2'd2; r[2] = 2'd1; end
            default: begin r[0] = RANK_NEVER; r[1] = RANK_NEVER; r[2] = RANK_NEVER; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/svm7_edges.sv
module svm7_edges
    import svm7_pkg::*;
#(
    parameter int TW = 12,
    parameter int EW = TW + 2
) (
    input  logic [2:0]                     sector_i,
    input  logic [TW-1:0]                  ta_i,
    input  logic [TW-1:0]                  tb_i,
    input  logic [TW-1:0]                  t0_i,
    output logic [NUM_EDGES-1:0][EW-1:0]   edges_o,
    output logic [EW-1:0]                  last_o,
    output rank_set_t                      ranks_o
);

    logic [EW-1:0] half_a, half_b, quarter0, first_len, second_len, total;

    always_comb begin
        half_a   = EW'(ta_i >> 1);
        half_b   = EW'(tb_i >> 1);
        quarter0 = EW'(t0_i >> 2);
        total    = EW'(ta_i) + EW'(tb_i) + EW'(t0_i);
        // Odd sectors visit the ta vector first, even sectors the tb vector.
        first_len  = sector_i[0] ? half_a : half_b;
        second_len = sector_i[0] ? half_b : half_a;

        edges_o[0] = quarter0;
        edges_o[1] = edges_o[0] + first_len;
        edges_o[2] = edges_o[1] + second_len;
        edges_o[3] = total - edges_o[2];
        edges_o[4] = edges_o[3] + second_len;
        edges_o[5] = edges_o[4] + first_len;

        last_o  = (total == '0) ? '0 : total - EW'(1);
        ranks_o = sector_ranks(sector_i);
    end

endmodule

// File: rtl/svm7_leg_decode.sv
module svm7_leg_decode
    import svm7_pkg::*;
#(
    parameter int EW = 14
) (
    input  logic [EW-1:0]                  tick_i,
    input  logic [NUM_EDGES-1:0][EW-1:0]   edges_i,
    input  rank_set_t                      ranks_i,
    output logic [NUM_LEGS-1:0]            leg_o
);

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        logic       leg_on;
        logic [2:0] rise_idx, fall_idx;

        always_comb begin
            rise_idx = {1'b0, ranks_i[g]};
            fall_idx = 3'd5 - rise_idx;
            leg_on   = 1'b0;
            if (ranks_i[g] != RANK_NEVER) begin
                leg_on = (tick_i >= edges_i[rise_idx]) && (tick_i < edges_i[fall_idx]);
            end
        end

        assign leg_o[g] = leg_on;
    end

endmodule

// File: rtl/svm7_gate_seq.sv
module svm7_gate_seq
    import svm7_pkg::*;
#(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    sector_i,
    input  logic [TW-1:0] ta_i,
    input  logic [TW-1:0] tb_i,
    input  logic [TW-1:0] t0_i,
    output logic [2:0]    leg_o,
    output logic          start_o
);

    localparam int EW = TW + 2;

    typedef struct packed {
        logic                          run;
        logic [EW-1:0]                 tick;
        logic [EW-1:0]                 last;
        logic [NUM_EDGES-1:0][EW-1:0]  edges;
        rank_set_t                     ranks;
        logic                          strt;
    } core_t;

    core_t                         core_d, core_q;
    logic [NUM_LEGS-1:0]           leg_d, leg_q;
    logic [NUM_EDGES-1:0][EW-1:0]  new_edges;
    logic [EW-1:0]                 new_last;
    rank_set_t                     new_ranks;

    svm7_edges #(.TW(TW), .EW(EW)) i_edges (
        .sector_i (sector_i),
        .ta_i     (ta_i),
        .tb_i     (tb_i),
        .t0_i     (t0_i),
        .edges_o  (new_edges),
        .last_o   (new_last),
        .ranks_o  (new_ranks)
    );

    always_comb begin
        core_d      = core_q;
        core_d.strt = 1'b0;
        if (!core_q.run || core_q.tick == core_q.last) begin
            core_d.run   = 1'b1;
            core_d.tick  = '0;
            core_d.last  = new_last;
            core_d.edges = new_edges;
            core_d.ranks = new_ranks;
            core_d.strt  = 1'b1;
        end else begin
            core_d.tick = core_q.tick + EW'(1);
        end
    end

    svm7_leg_decode #(.EW(EW)) i_decode (
        .tick_i  (core_d.tick),
        .edges_i (core_d.edges),
        .ranks_i (core_d.ranks),
        .leg_o   (leg_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
            leg_q  <= '0;
        end else begin
            core_q <= core_d;
            leg_q  <= leg_d;
        end
    end

    assign leg_o   = leg_q;
    assign start_o = core_q.strt;

    // Helper for the step check: a valid sector with all seven steps non-empty.
    logic segs_ok;
    always_comb begin
        segs_ok = (core_q.ranks[0] != RANK_NEVER)
               && (core_q.edges[0] != '0)
               && (core_q.edges[1] > core_q.edges[0])
               && (core_q.edges[2] > core_q.edges[1])
               && (core_q.edges[3] > core_q.edges[2]);
    end

    AST_TICK_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.run |-> core_q.tick <= core_q.last); // R2

    AST_HOLD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.run && core_q.tick != core_q.last |=>
            $stable(core_q.edges) && $stable(core_q.ranks) && $stable(core_q.last)); // R7

    AST_OUTER_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.run && (core_q.tick < core_q.edges[0] || core_q.tick >= core_q.edges[5])
            |-> leg_q == 3'b000); // R6

    AST_CENTRE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.run && core_q.ranks[0] != RANK_NEVER
            && core_q.tick >= core_q.edges[2] && core_q.tick < core_q.edges[3]
            |-> leg_q == 3'b111); // R6

    AST_BAD_SECTOR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.run && core_q.ranks[0] == RANK_NEVER |-> leg_q == 3'b000); // R8

    AST_ONE_LEG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(core_q.run && segs_ok) && segs_ok
            |-> $countones(leg_q ^ $past(leg_q)) <= 1); // R6

endmodule

// File: tb/test_svm7_gate_seq.sv
module test_svm7_gate_seq;

    localparam int CLK_PERIOD = 10;
    localparam int TW         = 12;
    localparam int END_CYCLE  = 5000;
    localparam int WATCHDOG   = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    sector_i = '0;
    logic [TW-1:0] ta_i = '0, tb_i = '0, t0_i = '0;
    logic [2:0]    leg_o;
    logic          start_o;

    svm7_gate_seq #(.TW(TW)) i_svm7_gate_seq (
        .clk(clk), .rst_n(rst_n), .sector_i(sector_i),
        .ta_i(ta_i), .tb_i(tb_i), .t0_i(t0_i),
        .leg_o(leg_o), .start_o(start_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [2:0] expq[$];
    logic [2:0] exp_leg;
    logic       exp_start;
    int         cur_tag  = 1;
    int         pend_tag = 3;

    int d_tag[$], d_sec[$], d_ta[$], d_tb[$], d_t0[$];

    function automatic string tag_name(input int t);
        case (t)
            1: return "R1";  2: return "R2";  3: return "R3";
            4: return "R4";  5: return "R5";  6: return "R6";
            7: return "R7";  8: return "R8";  default: return "R9";
        endcase
    endfunction

    // R4 vector table: bit0 = A, bit1 = B, bit2 = C, 1 = upper on
    function automatic logic [2:0] vec(input int n);
        case (n)
            1: return 3'b001;  2: return 3'b011;  3: return 3'b010;
            4: return 3'b110;  5: return 3'b100;  default: return 3'b101;
        endcase
    endfunction

    task automatic push_n(input logic [2:0] v, input int n);
        for (int i = 0; i < n; i++) expq.push_back(v);
    endtask

    task automatic build(input int sec, input int ta, input int tb, input int t0);
        int total = ta + tb + t0;
        if (sec < 1 || sec > 6) begin
            push_n(3'b000, (total == 0) ? 1 : total);
        end else begin
            int ha = ta / 2, hb = tb / 2, q = t0 / 4;
            int c = total - 2*q - 2*ha - 2*hb;
            logic [2:0] va = vec(sec), vb = vec(sec % 6 + 1);
            logic [2:0] f, s;
            int df, ds;
            if (sec % 2 == 1) begin f = va; df = ha; s = vb; ds = hb; end
            else              begin f = vb; df = hb; s = va; ds = ha; end
            push_n(3'b000, q); push_n(f, df); push_n(s, ds); push_n(3'b111, c);
            push_n(s, ds); push_n(f, df); push_n(3'b000, q);
            if (expq.size() == 0) expq.push_back(3'b000);
        end
    endtask

    task automatic add(input int t, input int s, input int a, input int b, input int z);
        d_tag.push_back(t); d_sec.push_back(s); d_ta.push_back(a);
        d_tb.push_back(b); d_t0.push_back(z);
    endtask

    initial begin
        add(1, 1, 8, 6, 12);   // R1 first period after reset
        add(4, 1, 10, 6, 12);  // R4
        add(4, 3, 10, 6, 12);  // R4
        add(4, 5, 9, 7, 13);   // R4 with odd remainders
        add(5, 2, 10, 6, 12);  // R5
        add(5, 4, 4, 8, 16);   // R5
        add(5, 6, 12, 2, 8);   // R5
        add(3, 1, 5, 7, 7);    // R3 remainders into centre
        add(9, 2, 6, 4, 2);    // R9 t0 < 4
        add(9, 1, 0, 6, 8);    // R9 ta = 0
        add(8, 0, 5, 5, 5);    // R8
        add(8, 7, 3, 0, 0);    // R8
        add(2, 3, 0, 0, 0);    // R2 all-zero dwell, length 1
        add(2, 4, 0, 0, 1);    // R2 length 1
        add(7, 5, 20, 20, 20); // R7 long period, inputs scrambled meanwhile
        add(6, 6, 8, 8, 8);    // R6 all steps non-empty
        add(6, 3, 6, 10, 12);  // R6
    end

    always @(negedge clk) begin
        if (!done) begin
            cyc++;
            // Model step for the rising edge just passed
            if (!rst_n) begin
                expq.delete();
                exp_leg = 3'b000; exp_start = 1'b0; cur_tag = 1;
            end else begin
                if (expq.size() == 0) begin
                    build(int'(sector_i), int'(ta_i), int'(tb_i), int'(t0_i));
                    exp_start = 1'b1;
                    cur_tag   = pend_tag;
                end else begin
                    exp_start = 1'b0;
                end
                exp_leg = expq.pop_front();
            end

            checks++;
            if (leg_o !== exp_leg) begin
                fails++;
                $display("FAIL %s cycle %0d leg_o actual %b expected %b",
                         tag_name(cur_tag), cyc, leg_o, exp_leg);
            end
            checks++;
            if (start_o !== exp_start) begin
                fails++;
                $display("FAIL %s cycle %0d start_o actual %b expected %b",
                         (cur_tag == 1) ? "R1" : "R2", cyc, start_o, exp_start);
            end

            // Next stimulus; R1 mid-run reset at cycles 300..301
            rst_n = (cyc >= 3) && !(cyc >= 300 && cyc < 302);
            if (rst_n && expq.size() == 0 && d_sec.size() != 0) begin
                pend_tag = d_tag.pop_front();
                sector_i = 3'(d_sec.pop_front());
                ta_i = TW'(d_ta.pop_front());
                tb_i = TW'(d_tb.pop_front());
                t0_i = TW'(d_t0.pop_front());
            end else if (rst_n && expq.size() == 0) begin
                pend_tag = 3;  // R3 random periods
                sector_i = 3'($urandom_range(0, 7));
                ta_i = TW'($urandom_range(0, 40));
                tb_i = TW'($urandom_range(0, 40));
                t0_i = TW'($urandom_range(0, 40));
            end else begin
                // R7: junk while a period runs
                sector_i = 3'($urandom_range(0, 7));
                ta_i = TW'($urandom_range(0, 4095));
                tb_i = TW'($urandom_range(0, 4095));
                t0_i = TW'($urandom_range(0, 4095));
            end

            if (cyc >= END_CYCLE) begin
                done = 1'b1;
                $display("  [TB] %0d tests run, %0d failed", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule